// File: doc/BRIEF.md
# Power-Management Companion Bridge

This block sits on the host side of a chip and gives a processor access to the registers of a companion power-management device. The processor sees a small 32-bit register port. Stores into a slave address window are queued in a write FIFO. Writing a slave offset into a command register starts a read. The read result, the write-FIFO flags and two sticky error bits can be read back at any time.

A sequencer serves the serial link to the companion device. That link is modelled here as a responder with a fixed, parameterised latency, backed by a small register file. The sequencer always empties the write FIFO before it starts a pending read, so a read returns the effect of every earlier write.

Three address modes are selected by the parameter `ADDR_MODE`:

| ADDR_MODE | Window base | Window size | Slave select | Echoed address |
|---|---|---|---|---|
| 0 | 0x8000 | 4 KiB | none | offset bits 14:0 |
| 1 | 0x8000 | 16 KiB | offset bits 13:12 | offset bits 16:2 |
| 2 | 0x20000 | 128 KiB | offset bits 16:15 | offset bits 16:2 |

In modes 1 and 2, slave select value 3 is invalid. The register offsets are: command at 0x0 (write only), read result at 0x4, status at 0x8.

Top module: `pmic_bridge`

## Requirements
- R1: After reset, the read-result register (0x4) reads 0 and the status register (0x8) reads 0x400: FIFO empty, not full, no errors.
- R2: A valid read command sets the busy bit (bit 31 of 0x4) at the clock edge that accepts the command. Busy stays set until the reply is captured. With an empty FIFO and an idle link, busy reads 1 for exactly LAT+2 sampled cycles.
- R3: A completed read leaves the slave data in bits 15:0 of 0x4. Bits 30:16 hold the echoed address: offset bits 16:2 in modes 1 and 2, offset bits 14:0 in mode 0.
- R4: A store to an address in [window base, window base + window size) queues its low 16 data bits for the slave register at that offset. A later read returns the last value stored, even if the read is issued while earlier stores are still queued.
- R5: Status bit 10 is the FIFO-empty flag. Status bit 11 is the FIFO-full flag, set when DEPTH entries are held. The two flags are never set together.
- R6: A window store made while the FIFO is full is dropped and sets status bit 0 (overflow). That bit stays set until software writes 1 to bit 0 of the status register.
- R7: A read offset at or beyond the window size does not set busy. It sets status bit 1 (read error) and leaves register 0x4 unchanged. The next valid read command clears the error bit.
- R8: In modes 1 and 2, an offset whose slave-select bits are 3 counts as out of range: a read sets the error bit and a store is dropped.
- R9: A read command written while busy is set is ignored. The in-flight read completes with its own address and data.
- R10: Reading register 0x4 or 0x8 has no side effect. Repeated reads return the same value.
- R11: A store to an address that is neither inside the window nor a register has no effect on any slave register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register-port access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
Register reads are combinational, so a value is due at the first sample after the clock edge that updates the state behind it. The busy bit rises at the edge that accepts the command. An out-of-range read sets the error bit at that same edge. A store is counted in the FIFO flags one edge after it is presented. Busy clears LAT+2 edges after the command, because of one edge to launch the read, LAT edges in the responder and one edge to capture the reply. The bench drives every access on the falling clock edge and samples one step later. It counts busy samples cycle by cycle for the exact-latency check. Elsewhere it polls busy with a bounded loop, lets the FIFO drain before checks that assume an idle link, and paces the fill test so that it knows, edge by edge, how many entries the FIFO holds.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;
  localparam int OFF_W  = 17;
  localparam int DATA_W = 16;
  localparam int ECHO_W = 15;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] data;
  } wr_ent_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WR   = 2'd1,
    SEQ_RD   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pmic_wfifo.sv
module pmic_wfifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pmic_link_model.sv
module pmic_link_model #(
  parameter int LAT    = 4,
  parameter int REGS   = 16,
  parameter int OFF_W  = 17,
  parameter int DATA_W = 16,
  localparam int IW    = $clog2(REGS),
  localparam int CW    = $clog2(LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [REGS];
  logic [CW-1:0]     cnt_q;
  logic              busy_q, done_q, wr_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] wd_q, rd_q;

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      for (int i = 0; i < REGS; i++) mem_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (wr_q) mem_q[idx_q] <= wd_q;
          else      rd_q <= mem_q[idx_q];
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(LAT - 1);
        wr_q   <= wr_i;
        idx_q  <= off_i[IW+1:2];
        wd_q   <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/pmic_link_seq.sv
module pmic_link_seq
  import pmic_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  wr_ent_t           fifo_ent_i,
  input  logic              rd_pend_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  input  logic              link_done_i,
  output logic              pop_o,
  output logic              start_o,
  output logic              wr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_done_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    pop_o   = 1'b0;
    start_o = 1'b0;
    wr_o    = 1'b0;
    off_o   = rd_off_i;
    wdata_o = fifo_ent_i.data;
    case (st_q)
      SEQ_IDLE: begin
        // queued writes go first so reads see them
        if (!fifo_empty_i) begin
          pop_o   = 1'b1;
          start_o = 1'b1;
          wr_o    = 1'b1;
          off_o   = fifo_ent_i.off;
          st_d    = SEQ_WR;
        end else if (rd_pend_i) begin
          start_o = 1'b1;
          st_d    = SEQ_RD;
        end
      end
      SEQ_WR:  if (link_done_i) st_d = SEQ_IDLE;
      SEQ_RD:  if (link_done_i) st_d = SEQ_IDLE;
      default: st_d = SEQ_IDLE;
    endcase
  end

  assign rd_done_o = (st_q == SEQ_RD) && link_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int ADDR_MODE = 2,
  parameter int DEPTH     = 4,
  parameter int LAT       = 4,
  parameter int REGS      = 16,
  parameter int CMD_W     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int WIN_BASE = (ADDR_MODE == 2) ? 32'h2_0000 : 32'h8000;
  localparam int WIN_SIZE = (ADDR_MODE == 0) ? 4096 : (ADDR_MODE == 1) ? 16384 : 131072;
  localparam int SID_LSB  = (ADDR_MODE == 2) ? 15 : 12;
  localparam int REG_CMD  = 0;
  localparam int REG_DATA = 4;
  localparam int REG_STAT = 8;
  localparam int ENT_W    = $bits(wr_ent_t);

  function automatic logic off_ok(input logic [CMD_W-1:0] off);
    logic in_win, sid_ok;
    in_win = (32'(off) < WIN_SIZE);
    sid_ok = (ADDR_MODE == 0) || (off[SID_LSB +: 2] != 2'b11);
    return in_win && sid_ok;
  endfunction

  logic [31:0]       addr_ext;
  logic              wr_acc, cmd_wr, stat_clr, win_hit, win_wr;
  logic [OFF_W-1:0]  win_off;
  logic [CMD_W-1:0]  cmd_off;
  logic [ECHO_W-1:0] echo_nx;

  logic              busy_q, rd_pend_q, err_q, ovf_q;
  logic [OFF_W-1:0]  rd_off_q;
  logic [ECHO_W-1:0] echo_q;
  logic [DATA_W-1:0] data_q;
  logic [31:0]       data_reg;

  wr_ent_t           push_ent, pop_ent;
  logic [ENT_W-1:0]  pop_raw;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;

  logic              lk_start, lk_wr, lk_busy, lk_done, rd_done;
  logic [OFF_W-1:0]  lk_off;
  logic [DATA_W-1:0] lk_wdata, lk_rdata;

  assign addr_ext = 32'(addr_i);
  assign wr_acc   = req_i && we_i;
  assign cmd_wr   = wr_acc && (addr_ext == REG_CMD);
  assign stat_clr = wr_acc && (addr_ext == REG_STAT) && wdata_i[0];
  assign win_hit  = (addr_ext >= WIN_BASE) && (addr_ext < WIN_BASE + WIN_SIZE);
  assign win_off  = OFF_W'(addr_ext - WIN_BASE);
  assign win_wr   = wr_acc && win_hit && off_ok(CMD_W'(win_off));
  assign cmd_off  = wdata_i[CMD_W-1:0];

  generate
    if (ADDR_MODE == 0) begin : g_echo_low
      assign echo_nx = cmd_off[ECHO_W-1:0];
    end else begin : g_echo_word
      assign echo_nx = cmd_off[ECHO_W+1:2];
    end
  endgenerate

  assign push_ent.off  = win_off;
  assign push_ent.data = wdata_i[DATA_W-1:0];
  assign fifo_push     = win_wr && !fifo_full;
  assign pop_ent       = wr_ent_t'(pop_raw);

  pmic_wfifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .din_i   (push_ent),
    .dout_o  (pop_raw),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  pmic_link_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty),
    .fifo_ent_i   (pop_ent),
    .rd_pend_i    (rd_pend_q),
    .rd_off_i     (rd_off_q),
    .link_done_i  (lk_done),
    .pop_o        (fifo_pop),
    .start_o      (lk_start),
    .wr_o         (lk_wr),
    .off_o        (lk_off),
    .wdata_o      (lk_wdata),
    .rd_done_o    (rd_done)
  );

  pmic_link_model #(.LAT(LAT), .REGS(REGS), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_link (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lk_start),
    .wr_i    (lk_wr),
    .off_i   (lk_off),
    .wdata_i (lk_wdata),
    .busy_o  (lk_busy),
    .done_o  (lk_done),
    .rdata_o (lk_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      err_q     <= 1'b0;
      ovf_q     <= 1'b0;
      rd_off_q  <= '0;
      echo_q    <= '0;
      data_q    <= '0;
    end else begin
      if (cmd_wr && !busy_q) begin
        if (off_ok(cmd_off)) begin
          busy_q    <= 1'b1;
          rd_pend_q <= 1'b1;
          rd_off_q  <= OFF_W'(cmd_off);
          echo_q    <= echo_nx;
          err_q     <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (lk_start && !lk_wr) rd_pend_q <= 1'b0;
      if (rd_done) begin
        busy_q <= 1'b0;
        data_q <= lk_rdata;
      end
      if (win_wr && fifo_full) ovf_q <= 1'b1;
      else if (stat_clr)       ovf_q <= 1'b0;
    end
  end

  assign data_reg = {busy_q, echo_q, data_q};

  always_comb begin
    rdata_o = '0;
    case (addr_ext)
      REG_DATA: rdata_o = data_reg;
      REG_STAT: begin
        rdata_o[11] = fifo_full;
        rdata_o[10] = fifo_empty;
        rdata_o[1]  = err_q;
        rdata_o[0]  = ovf_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_wr_i,
  input logic        stat_clr_i,
  input logic        busy_i,
  input logic        err_i,
  input logic        ovf_i,
  input logic        rd_done_i,
  input logic        full_i,
  input logic        empty_i,
  input logic [31:0] data_reg_i
);
  // R2
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_i) |=> (busy_i || err_i));

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_done_i) |=> busy_i);

  // R5
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_i && empty_i));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !stat_clr_i) |=> ovf_i);

  // R7
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> !busy_i);

  // R10
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_done_i && !cmd_wr_i) |=> $stable(data_reg_i));
endmodule

bind pmic_bridge pmic_bridge_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_wr_i   (cmd_wr),
  .stat_clr_i (stat_clr),
  .busy_i     (busy_q),
  .err_i      (err_q),
  .ovf_i      (ovf_q),
  .rd_done_i  (rd_done),
  .full_i     (fifo_full),
  .empty_i    (fifo_empty),
  .data_reg_i (data_reg)
);

// File: tb/pmic_bridge_tb.sv
module pmic_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  typedef struct packed {
    logic [1:0]  op;    // 0 store, 1 read command, 2 status read
    logic [18:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 19'h20004, 32'h0000_1234, 32'h0},
    '{2'd0, 19'h20008, 32'h0000_BEEF, 32'h0},
    '{2'd1, 19'h0,     32'h0000_0004, 32'h0001_1234},
    '{2'd1, 19'h0,     32'h0000_0008, 32'h0002_BEEF},
    '{2'd0, 19'h28004, 32'h0000_5555, 32'h0},
    '{2'd1, 19'h0,     32'h0000_8004, 32'h2001_5555},
    '{2'd1, 19'h0,     32'h0001_0040, 32'h4010_0000},
    '{2'd0, 19'h20004, 32'h0000_A0A0, 32'h0},
    '{2'd1, 19'h0,     32'h0000_0004, 32'h0001_A0A0},
    '{2'd2, 19'h8,     32'h0,         32'h0000_0400}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd2, rd0;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_bridge #(.ADDR_MODE(2), .LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd2));

  pmic_bridge #(.ADDR_MODE(0), .LAT(LAT)) u_dut_m0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd0));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [18:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic peek(input logic [18:0] a);
    addr = a; #1;
  endtask

  task automatic wait_idle();
    peek(19'h4);
    for (int i = 0; i < 100; i++) begin
      if (!rd2[31] && !rd0[31]) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R2 busy never cleared)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    peek(19'h4); chk("R1 data reg", rd2, 32'h0); chk("R1 data reg m0", rd0, 32'h0);
    peek(19'h8); chk("R1 status", rd2, 32'h400); chk("R1 status m0", rd0, 32'h400);

    // R3/R4 vectors, mode 2
    foreach (VECS[i]) begin
      case (VECS[i].op)
        2'd0: bus_wr(VECS[i].addr, VECS[i].data);
        2'd1: begin
          bus_wr(19'h0, VECS[i].data);
          wait_idle();
          chk($sformatf("R3/R4 vector %0d", i), rd2, VECS[i].exp);
        end
        default: begin
          settle(20); peek(VECS[i].addr);
          chk($sformatf("R5 vector %0d", i), rd2, VECS[i].exp);
        end
      endcase
    end

    // R2 exact busy window
    settle(20);
    bus_wr(19'h0, 32'h8);
    peek(19'h4); n = 0;
    while (rd2[31] && n < 100) begin n++; @(negedge clk); #1; end
    chk("R2 busy cycles", 32'(n), 32'(LAT + 2));
    chk("R2 result", rd2, 32'h0002_BEEF);

    // R10 repeated reads change nothing
    for (int k = 0; k < 6; k++) begin
      req = 1'b1; we = 1'b0; addr = (k % 2) ? 19'h8 : 19'h4;
      @(negedge clk);
    end
    req = 1'b0;
    peek(19'h4); chk("R10 data reg after reads", rd2, 32'h0002_BEEF);
    peek(19'h8); chk("R10 status after reads", rd2, 32'h400);

    // R9 second command while busy is ignored
    bus_wr(19'h0, 32'h4);
    bus_wr(19'h0, 32'h8);
    wait_idle();
    chk("R9 first read wins", rd2, 32'h0001_A0A0);

    // R7 out-of-range read
    bus_wr(19'h0, 32'h2_0000);
    peek(19'h4); chk("R7 no busy, data unchanged", rd2, 32'h0001_A0A0);
    peek(19'h8); chk("R7 error bit", rd2 & 32'h2, 32'h2);
    bus_wr(19'h0, 32'h8);
    wait_idle();
    peek(19'h8); chk("R7 error cleared", rd2 & 32'h2, 32'h0);

    // R8 slave select 3
    bus_wr(19'h0, 32'h1_8000);
    peek(19'h8); chk("R8 read error", rd2 & 32'h2, 32'h2);
    bus_wr(19'h3803C, 32'h9999);
    settle(20);
    bus_wr(19'h0, 32'h3C);
    wait_idle();
    chk("R8 store dropped", rd2, 32'h000F_0000);

    // R5/R6 fill the FIFO, sixth store dropped
    settle(20);
    for (int k = 0; k < 6; k++) bus_wr(19'h20020 + 19'(4 * k), 32'h100 + 32'(k));
    peek(19'h8); chk("R5/R6 full and overflow", rd2 & 32'hC01, 32'h801);
    bus_wr(19'h8, 32'h1);
    peek(19'h8); chk("R6 overflow cleared", rd2 & 32'h1, 32'h0);
    settle(40);
    peek(19'h8); chk("R5 empty after drain", rd2, 32'h400);
    bus_wr(19'h0, 32'h34);
    wait_idle(); chk("R6 dropped store absent", rd2, 32'h000D_0000);
    bus_wr(19'h0, 32'h30);
    wait_idle(); chk("R4 fifth store present", rd2, 32'h000C_0104);

    // R3/R11 mode 0: echo of low offset bits, mode-2 stores outside its window
    bus_wr(19'h0, 32'h4);
    wait_idle(); chk("R11/R3 mode0 read", rd0, 32'h0004_0000);
    bus_wr(19'h8010, 32'h77);
    settle(20);
    bus_wr(19'h0, 32'h10);
    wait_idle();
    chk("R4 mode0 store", rd0, 32'h0010_0077);
    chk("R11 mode2 ignores foreign store", rd2, 32'h0004_0000);
    bus_wr(19'h0, 32'h7FC);
    wait_idle(); chk("R3 mode0 echo", rd0, 32'h07FC_0000);
    bus_wr(19'h0, 32'h1000);
    peek(19'h8); chk("R7 mode0 range error", rd0 & 32'h2, 32'h2);
    chk("R7 mode2 accepts same offset", rd2 & 32'h2, 32'h0);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule